// File: doc/BRIEF.md
# Four-Phase Memory Read Master

This block connects a simple core-side request port to an external memory bus and runs each read as a fixed four-clock transaction. The core raises `req_i` for one cycle with an address while `ready_o` is high. The block stores that address and then drives the bus in a fixed order. First it puts the address on the bus. Next it pulls the active-low read strobe low. It holds the strobe low for one wait cycle while the memory drives its data. Last it releases the strobe, and on that release edge it registers the data bus value.

The core sees a one-cycle `done_o` pulse. During that pulse `rdata_o` already holds the returned operand. `rdata_o` keeps that value until the next read completes. The block refuses any request that arrives mid-transaction and keeps no queue. A request accepted in the final cycle of a read starts a new transaction on the very next clock, so reads issued back to back each take exactly four bus cycles.

Top module: `mem_read_master`

## Requirements
- R1: While `rst_ni` is low the block is idle, with `rd_no` high, `done_o` low and `ready_o` high.
- R2: When `req_i` is high with `ready_o` high at a rising edge, the next cycle (bus cycle 1) drives `addr_o` equal to the sampled `addr_i`, with `rd_no` still high and `ready_o` low.
- R3: In bus cycle 2, `rd_no` is low.
- R4: In bus cycle 3 (the wait cycle), `rd_no` stays low, so the strobe is low for exactly two consecutive cycles.
- R5: In bus cycle 4, `rd_no` is high and `done_o` is high for exactly that one cycle. `rdata_o` equals the value that was on `data_i` during cycle 3.
- R6: `addr_o` holds the same value from cycle 1 through cycle 4.
- R7: `ready_o` is low in cycles 1 to 3. A request made in those cycles is dropped: it changes neither `addr_o` nor the bus sequence, and no extra transaction follows it.
- R8: `ready_o` is high in cycle 4. A request accepted there makes the next cycle bus cycle 1 of a new read, so back-to-back reads take four cycles each.
- R9: `rdata_o` keeps its value after `done_o` falls, until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, sampled when ready_o is high |
| addr_i | input | AW | Requested address |
| ready_o | output | 1 | High when a request can be accepted |
| done_o | output | 1 | One-cycle pulse when rdata_o is valid |
| rdata_o | output | DW | Registered read data |
| addr_o | output | AW | Memory address bus |
| rd_no | output | 1 | Read strobe, active low |
| data_i | input | DW | Memory data bus |

## Verification
The hardest case to reach from the ports is proving that data is captured on the strobe-release edge and on no other edge. The bench memory model drives valid data only while the strobe has been low for a full cycle, and it drives a decoy value at every other time. A capture one cycle early or one cycle late therefore shows up as a wrong `rdata_o`. Other stimulus chains requests into cycle 4 and injects refused requests in the middle of a transaction, so that the back-to-back timing and the no-queue rule are both observed at the bus.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ADDR    = 3'd1,
    PH_STROBE  = 3'd2,
    PH_WAIT    = 3'd3,
    PH_RELEASE = 3'd4
  } phase_e;
endpackage

// File: rtl/mrm_phase_ctrl.sv
module mrm_phase_ctrl
  import mrm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ready_o,
  output logic load_o,
  output logic capture_o,
  output logic strobe_no,
  output logic done_o
);
  phase_e phase_q, phase_d;

  assign ready_o = (phase_q == PH_IDLE) || (phase_q == PH_RELEASE);
  assign load_o  = ready_o && req_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (req_i) phase_d = PH_ADDR;
      PH_ADDR:    phase_d = PH_STROBE;
      PH_STROBE:  phase_d = PH_WAIT;
      PH_WAIT:    phase_d = PH_RELEASE;
      PH_RELEASE: phase_d = req_i ? PH_ADDR : PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  // capture on the edge that leaves the wait cycle, i.e. strobe release
  assign capture_o = (phase_q == PH_WAIT);
  assign strobe_no = !((phase_q == PH_STROBE) || (phase_q == PH_WAIT));
  assign done_o    = (phase_q == PH_RELEASE);
endmodule

// File: rtl/mrm_hold_reg.sv
module mrm_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/mem_read_master.sv
module mem_read_master #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_no,
  input  logic [DW-1:0] data_i
);
  logic load, capture;

  mrm_phase_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ready_o   (ready_o),
    .load_o    (load),
    .capture_o (capture),
    .strobe_no (rd_no),
    .done_o    (done_o)
  );

  mrm_hold_reg #(.W(AW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (load),
    .d_i    (addr_i),
    .q_o    (addr_o)
  );

  mrm_hold_reg #(.W(DW)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (capture),
    .d_i    (data_i),
    .q_o    (rdata_o)
  );
endmodule

// File: rtl/mem_read_master_chk.sv
module mem_read_master_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [AW-1:0] addr_i,
  input logic          ready_o,
  input logic          done_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW-1:0] addr_o,
  input logic          rd_no,
  input logic [DW-1:0] data_i
);
  assert_idle_on_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_no && !done_o && ready_o));

  assert_accept_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> (rd_no && !ready_o && addr_o == $past(addr_i)));

  assert_strobe_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no && !ready_o) |=> !rd_no);

  assert_strobe_two_cycles_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |=> !rd_no);

  assert_strobe_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && $past(!rd_no)) |=> (rd_no && done_o));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_capture_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_no) |-> (rdata_o == $past(data_i)));

  assert_addr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || done_o) |-> $stable(addr_o));

  assert_busy_refuse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ready_o);

  assert_ready_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(rd_no) |-> $stable(rdata_o));
endmodule

bind mem_read_master mem_read_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .addr_i  (addr_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .rdata_o (rdata_o),
  .addr_o  (addr_o),
  .rd_no   (rd_no),
  .data_i  (data_i)
);

// File: tb/mem_read_master_test.sv
`timescale 1ns/1ps
module mem_read_master_test;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int NV = 6;
  localparam logic [DW-1:0] DECOY = 8'hEE;

  localparam logic [AW-1:0] VEC_ADDR [NV] = '{16'h0000, 16'h1234, 16'hFFFF, 16'hA5C3, 16'h00FF, 16'h8001};
  localparam bit            VEC_CHAIN[NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 0, rst_ni = 0, req = 0;
  logic [AW-1:0] addr_in = '0;
  logic ready, done, rd_n, rd_q;
  logic [DW-1:0] rdata, data_bus;
  logic [AW-1:0] addr_bus;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mem_read_master #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr_in),
    .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .addr_o(addr_bus), .rd_no(rd_n), .data_i(data_bus)
  );

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: valid data only once the strobe has been low a full cycle
  always @(posedge clk) rd_q <= rd_n;
  assign data_bus = (!rd_n && !rd_q) ? mem_val(addr_bus) : DECOY;

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic drive_req(input logic [AW-1:0] a);
    req = 1; addr_in = a;
  endtask

  task automatic run_phases(input logic [AW-1:0] a, input bit chain, input logic [AW-1:0] na);
    @(negedge clk); req = 0; addr_in = ~a;
    chk("R2 addr", addr_bus, a);
    chk("R2 strobe", rd_n, 1);
    chk("R7 ready c1", ready, 0);
    @(negedge clk);
    chk("R3 strobe", rd_n, 0);
    chk("R6 addr c2", addr_bus, a);
    @(negedge clk);
    chk("R4 strobe", rd_n, 0);
    chk("R6 addr c3", addr_bus, a);
    @(negedge clk);
    chk("R5 strobe", rd_n, 1);
    chk("R5 done", done, 1);
    chk("R5 rdata", rdata, mem_val(a));
    chk("R6 addr c4", addr_bus, a);
    chk("R8 ready c4", ready, 1);
    if (chain) drive_req(na);
    else begin
      @(negedge clk);
      chk("R5 done pulse", done, 0);
      chk("R9 rdata hold", rdata, mem_val(a));
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 strobe", rd_n, 1);
    chk("R1 done", done, 0);
    chk("R1 ready", ready, 1);
    rst_ni = 1;
    @(negedge clk);

    drive_req(VEC_ADDR[0]);
    for (int i = 0; i < NV; i++) begin
      run_phases(VEC_ADDR[i], VEC_CHAIN[i], VEC_ADDR[(i + 1) % NV]);
      if (!VEC_CHAIN[i] && i < NV - 1) drive_req(VEC_ADDR[i + 1]);
    end

    // R7: request in cycle 2 is dropped
    drive_req(16'h4242);
    @(negedge clk); req = 0;
    @(negedge clk); drive_req(16'h7777);
    @(negedge clk); req = 0;
    chk("R7 addr unchanged", addr_bus, 16'h4242);
    @(negedge clk);
    chk("R7 done", done, 1);
    chk("R7 rdata", rdata, mem_val(16'h4242));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 no queued read strobe", rd_n, 1);
      chk("R7 no queued read done", done, 0);
      chk("R7 addr kept", addr_bus, 16'h4242);
    end

    // R1: reset in the wait cycle
    drive_req(16'h3C3C);
    @(negedge clk); req = 0;
    @(negedge clk); @(negedge clk);
    chk("R4 pre-reset strobe", rd_n, 0);
    rst_ni = 0;
    #1;
    chk("R1 mid strobe", rd_n, 1);
    chk("R1 mid done", done, 0);
    chk("R1 mid ready", ready, 1);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk("R1 idle after", rd_n, 1);
    chk("R1 no done after", done, 0);

    summary();
  end
endmodule